// File: doc/BRIEF.md
# Key-Sequence Erase Guard

This block holds one protected control bit, a software erase request, and allows software to set it only after a two-step key handshake on a 32-bit register bus. Software writes a first key and then a second key to a write-only key register. After that it may write the control/status register once. A write that sets the request bit there makes the block emit a single-cycle erase pulse toward the memory erase engine.

Any wrong key, at either step, throws the sequencer back to the locked state. Each unlock is good for exactly one write to the control/status register, after which protection comes back on its own. The current lock state is driven out as a plain status pin and can also be read back from the control/status register.

The register bus is a simple strobe interface with no back-pressure: every write and every read is accepted in the cycle it is presented. Read data is combinational from the current state while `rd_en` is high and is zero otherwise. The erase pulse and the unlocked pin are plain level outputs with no handshake.

Top module: `keylock_guard`

## Requirements
- R1: After reset the block is locked: `unlocked` is 0, `erase_pulse` is 0, and reads of both registers return zero.
- R2: A key-register write (offset 0x0) whose bits 7:0 equal 0xCA, followed by a key-register write whose bits 7:0 equal 0x53, sets `unlocked` to 1 one clock after the second write. The same state shows as bit 1 of the control/status register (offset 0x4).
- R3: In the locked state, any key value other than 0xCA leaves the block locked; 0x53 alone does not unlock. After 0xCA, any key value other than 0x53 (0xCA again included) returns the block to locked.
- R4: Reads, writes to offsets other than 0x0 and 0x4, and control/status writes made while not unlocked do not advance the key sequence and do not break it.
- R5: A control/status write while not unlocked has no effect: no erase pulse, and bit 0 reads 0.
- R6: A control/status write with bit 0 = 1 while unlocked raises `erase_pulse` for exactly one cycle, starting one clock after the write. During that cycle bit 0 of the control/status register reads 1; it reads 0 again afterwards.
- R7: Any control/status write made while unlocked, whatever the value of its bit 0, relocks the block one clock after the write.
- R8: Reads of the key register always return zero. Control/status bits 31:2 read zero. Key comparison uses bits 7:0 only, so bits 31:8 of a key write are ignored.
- R9: A key write while unlocked restarts the sequence: 0xCA moves the block to the half-way state (shown as locked), and any other value locks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| rd_en | input | 1 | Read strobe; read data is valid in the same cycle |
| addr | input | ADDR_W (4) | Byte offset: 0x0 key, 0x4 control/status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, zero when `rd_en` is low |
| erase_pulse | output | 1 | Single-cycle erase request |
| unlocked | output | 1 | High while one protected write is permitted |

## Verification
The bench builds the block with its defaults: a 4-bit offset space with the key register at 0x0 and the control/status register at 0x4, keys 0xCA and 0x53, the request bit at 0 and the status bit at 1. With a 4-bit offset space the unused offsets 0x8 and 0xC can be reached, so the bench can show that writes carrying the second key to an unused offset do not complete an unlock. The 32-bit data width lets key writes carry non-zero upper bits, which shows that only bits 7:0 are compared.

// File: rtl/keylock_pkg.sv
package keylock_pkg;
  // Sequencer states: idle, first key seen, one protected write permitted
  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_ARMED  = 2'd1,
    KS_OPEN   = 2'd2
  } kstate_e;
endpackage

// File: rtl/kseq_fsm.sv
module kseq_fsm
  import keylock_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          KEY_W  = 8,
  parameter logic [7:0]  KEY_A  = 8'hCA,
  parameter logic [7:0]  KEY_B  = 8'h53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              consume,
  output logic              open_q
);
  // Only the low KEY_W bits take part in the comparison
  localparam logic [DATA_W-1:0] KMASK = {{(DATA_W-KEY_W){1'b0}}, {KEY_W{1'b1}}};
  localparam logic [DATA_W-1:0] KA_W  = DATA_W'(KEY_A);
  localparam logic [DATA_W-1:0] KB_W  = DATA_W'(KEY_B);

  kstate_e state_q, state_d;
  logic    hit_a, hit_b;

  assign hit_a = ((wdata & KMASK) == KA_W);
  assign hit_b = ((wdata & KMASK) == KB_W);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      KS_LOCKED: if (key_wr) state_d = hit_a ? KS_ARMED : KS_LOCKED;
      KS_ARMED:  if (key_wr) state_d = hit_b ? KS_OPEN  : KS_LOCKED;
      KS_OPEN: begin
        if (key_wr)       state_d = hit_a ? KS_ARMED : KS_LOCKED;
        else if (consume) state_d = KS_LOCKED;
      end
      default: state_d = KS_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign open_q = (state_q == KS_OPEN);
endmodule

// File: rtl/prot_csr.sv
module prot_csr (
  input  logic clk,
  input  logic rst_n,
  input  logic csr_wr,
  input  logic req_bit,
  input  logic open_q,
  output logic consume,
  output logic erase_q
);
  // A write while open spends the unlock regardless of the data
  assign consume = csr_wr && open_q;

  // Set only from a permitted write; clears itself on the next edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) erase_q <= 1'b0;
    else        erase_q <= consume && req_bit;
  end
endmodule

// File: rtl/regbus_dec.sv
module regbus_dec #(
  parameter int              ADDR_W    = 4,
  parameter int              DATA_W    = 32,
  parameter logic [ADDR_W-1:0] KEY_OFS = 'h0,
  parameter logic [ADDR_W-1:0] CSR_OFS = 'h4,
  parameter int              REQ_BIT   = 0,
  parameter int              STAT_BIT  = 1
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              erase_q,
  input  logic              open_q,
  output logic              key_wr,
  output logic              csr_wr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] csr_view;

  assign key_wr = wr_en && (addr == KEY_OFS);
  assign csr_wr = wr_en && (addr == CSR_OFS);

  always_comb begin
    csr_view           = '0;
    csr_view[REQ_BIT]  = erase_q;
    csr_view[STAT_BIT] = open_q;
  end

  // Key register is write-only: it never appears on the read path
  assign rdata = (rd_en && (addr == CSR_OFS)) ? csr_view : '0;
endmodule

// File: rtl/keylock_guard.sv
module keylock_guard #(
  parameter int                ADDR_W  = 4,
  parameter int                DATA_W  = 32,
  parameter int                KEY_W   = 8,
  parameter logic [7:0]        KEY_A   = 8'hCA,
  parameter logic [7:0]        KEY_B   = 8'h53,
  parameter logic [ADDR_W-1:0] KEY_OFS = 'h0,
  parameter logic [ADDR_W-1:0] CSR_OFS = 'h4,
  parameter int                REQ_BIT = 0,
  parameter int                STAT_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              erase_pulse,
  output logic              unlocked
);
  logic key_wr, csr_wr, consume, open_q, erase_q;

  regbus_dec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_OFS(KEY_OFS), .CSR_OFS(CSR_OFS),
    .REQ_BIT(REQ_BIT), .STAT_BIT(STAT_BIT)
  ) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .erase_q(erase_q),
    .open_q(open_q), .key_wr(key_wr), .csr_wr(csr_wr), .rdata(rdata)
  );

  kseq_fsm #(
    .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .wdata(wdata),
    .consume(consume), .open_q(open_q)
  );

  prot_csr u_csr (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .req_bit(wdata[REQ_BIT]),
    .open_q(open_q), .consume(consume), .erase_q(erase_q)
  );

  assign erase_pulse = erase_q;
  assign unlocked    = open_q;
endmodule

// File: rtl/keylock_guard_chk.sv
module keylock_guard_chk #(
  parameter int                ADDR_W  = 4,
  parameter int                DATA_W  = 32,
  parameter logic [7:0]        KEY_B   = 8'h53,
  parameter logic [ADDR_W-1:0] KEY_OFS = 'h0,
  parameter logic [ADDR_W-1:0] CSR_OFS = 'h4,
  parameter int                REQ_BIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              erase_pulse,
  input logic              unlocked
);
  // R6: the pulse lasts a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |=> !erase_pulse);

  // R5 / R6: a pulse only follows a permitted write with the request bit set
  a_r5_pulse_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_pulse) |-> $past(wr_en && addr == CSR_OFS && wdata[REQ_BIT] && unlocked));

  // R7: a protected write spends the unlock
  a_r7_relock_after_use: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CSR_OFS && unlocked) |=> !unlocked);

  // R2: unlock is only ever completed by the second key landing on the key register
  a_r2_unlock_by_second_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_en && addr == KEY_OFS && wdata[7:0] == KEY_B));

  // R8: the key register never reads back
  a_r8_key_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == KEY_OFS) |-> (rdata == '0));

  // R1: nothing is read while no read is requested
  a_r1_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
endmodule

bind keylock_guard keylock_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_B(KEY_B),
  .KEY_OFS(KEY_OFS), .CSR_OFS(CSR_OFS), .REQ_BIT(REQ_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .erase_pulse(erase_pulse), .unlocked(unlocked)
);

// File: tb/sim_keylock_guard.sv
`timescale 1ns/1ps
module sim_keylock_guard;
  localparam logic [3:0] KOFS = 4'h0;
  localparam logic [3:0] COFS = 4'h4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        erase_pulse, unlocked;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model: 0 locked, 1 first key seen, 2 open
  int ms = 0;
  bit me = 1'b0;

  always #2.5 clk = ~clk;

  keylock_guard u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .erase_pulse(erase_pulse), .unlocked(unlocked)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit w, input bit r, input logic [3:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0] erd;
    bit          me_n;
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    #1;
    erd = (r && a == COFS) ? {30'b0, (ms == 2), me} : 32'h0;
    check(rdata, erd, tag);
    @(posedge clk);
    me_n = w && a == COFS && ms == 2 && d[0];
    if (w && a == KOFS) begin
      if (ms == 1) ms = (d[7:0] == 8'h53) ? 2 : 0;
      else         ms = (d[7:0] == 8'hCA) ? 1 : 0;
    end else if (w && a == COFS && ms == 2) ms = 0;
    me = me_n;
    #1;
    check({30'b0, unlocked, erase_pulse}, {30'b0, (ms == 2), me}, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    step(0, 1, COFS, 0, "R1");
    step(0, 1, KOFS, 0, "R1");
    step(0, 0, COFS, 0, "R1");
    // R5: protected write while locked
    step(1, 0, COFS, 32'h1, "R5");
    step(0, 1, COFS, 0, "R5");
    // R2: correct sequence
    step(1, 0, KOFS, 32'hCA, "R2");
    step(1, 0, KOFS, 32'h53, "R2");
    step(0, 1, COFS, 0, "R2");
    // R6: erase request and self-clear
    step(1, 0, COFS, 32'h1, "R6");
    step(0, 1, COFS, 0, "R6");
    step(0, 1, COFS, 0, "R6");
    // R7: write of zero still spends the unlock
    step(1, 0, KOFS, 32'hCA, "R7");
    step(1, 0, KOFS, 32'h53, "R7");
    step(1, 0, COFS, 32'h0, "R7");
    step(1, 0, COFS, 32'h1, "R7");
    step(0, 1, COFS, 0, "R7");
    // R3: wrong orders
    step(1, 0, KOFS, 32'h53, "R3");
    step(1, 0, KOFS, 32'hCA, "R3");
    step(1, 0, KOFS, 32'h00, "R3");
    step(1, 0, KOFS, 32'h53, "R3");
    step(1, 0, KOFS, 32'hCA, "R3");
    step(1, 0, KOFS, 32'hCA, "R3");
    step(1, 0, KOFS, 32'h53, "R3");
    // R8: upper key bits ignored, key reads zero
    step(1, 0, KOFS, 32'hFFFF_FFCA, "R8");
    step(0, 1, KOFS, 0, "R8");
    step(1, 0, KOFS, 32'h1234_5653, "R8");
    step(0, 1, KOFS, 0, "R8");
    step(1, 0, COFS, 32'hFFFF_FFFE, "R8");
    // R4: unrelated traffic between the two keys
    step(1, 0, KOFS, 32'hCA, "R4");
    step(0, 1, COFS, 0, "R4");
    step(1, 0, 4'h8, 32'h53, "R4");
    step(1, 0, 4'hC, 32'hCA, "R4");
    step(1, 0, COFS, 32'h1, "R4");
    step(1, 0, KOFS, 32'h53, "R4");
    step(0, 1, COFS, 0, "R4");
    // R9: key writes while open
    step(1, 0, KOFS, 32'hCA, "R9");
    step(1, 0, KOFS, 32'h53, "R9");
    step(1, 0, KOFS, 32'h11, "R9");
    step(1, 0, COFS, 32'h1, "R9");
    // mixed traffic, key values biased towards the two keys
    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      logic [3:0]  a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a  = {lf[3:2], 2'b00};
      case (lf[6:5])
        2'd0: d = 32'hCA;
        2'd1: d = 32'h53;
        2'd2: d = {16'h0, lf};
        default: d = {31'h0, lf[9]};
      endcase
      step(lf[7], lf[8], a, d, "R3");
    end
    finish_run();
  end
endmodule